// File: doc/BRIEF.md
# Flag-Flooding Routing Entry Builder

This block sits in each router of a 2D mesh and fills one routing-table entry for a chosen destination. Every router in the network receives the same start pulse, so all copies step together, one iteration per clock. The router that owns the destination marks its entry valid with the local direction. Every router holding a valid entry raises a one-bit flag toward each usable neighbour. A router still holding an invalid entry adopts the direction of a link on which a flag arrived. The result is a wave of flags that spreads outward from the destination.

Flags are filtered in both directions by link faults and link rules. A turn rule at the centre router stops a flag from going out on one link while the entry points along another link. With the default rule, the two turns of the northeast corner are disallowed. When flags arrive on several links in the same iteration, a fixed order picks one of them. After NODES-1 iterations the block presents the entry on a table write port for one cycle and pulses done. An entry that is still invalid at that point means the destination cannot be reached from this router.

Top module: `route_flood_engine`

## Requirements
- R1: Out of reset, `flag_o` is 0, `done_o` is 0 and `tbl_we_o` is 0. Outside a run, `flag_o` stays 0.
- R2: On `start_i` the entry is reset. When `dest_id_i` equals `self_id_i` the entry becomes valid with direction local (code 4). Otherwise it becomes invalid.
- R3: While a run is active and the entry is valid, a flag is driven on every link that is not blocked. An invalid entry drives no flags. Link bit and direction codes are: north=0, east=1, south=2, west=3.
- R4: An invalid entry that sees at least one accepted incoming flag in an iteration becomes valid in that iteration, with the direction of that link. Flags seen later, once the entry is valid, do not change it.
- R5: Among simultaneous accepted flags the direction is chosen in the order south, then east, then west, then north.
- R6: A run has exactly NODES-1 iterations. `done_o` and `tbl_we_o` are high for the single cycle after the last iteration and carry the entry and the latched `dest_id_i`.
- R7: If no flag is accepted during the run, the entry is written as invalid.
- R8: A link with its `link_fault_i` or `link_block_i` bit set accepts no incoming flag and drives no outgoing flag.
- R9: Bit k*4+d of `turn_block_i` stops the outgoing flag on link k while the entry points in direction d. A local entry is never affected by turn rules.
- R10: With parameter NE_RULE=1, bits 1 (entry east, no flag north) and 4 (entry north, no flag east) are always treated as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run; must be shared by all routers |
| dest_id_i | input | ID_W | Destination whose entry is being built |
| self_id_i | input | ID_W | This router's ID |
| link_fault_i | input | 4 | Faulty link per direction |
| link_block_i | input | 4 | Disallowed link per direction |
| turn_block_i | input | 16 | Disallowed turns, bit k*4+d |
| flag_i | input | 4 | Flags from the neighbours |
| flag_o | output | 4 | Flags to the neighbours |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_addr_o | output | ID_W | Table address (destination) |
| tbl_vld_o | output | 1 | Entry valid |
| tbl_dir_o | output | 3 | Entry direction |
| done_o | output | 1 | Run complete pulse |

## Verification
A wrong entry state shows up on `flag_o` in the cycle after it is taken. A wrongly set valid bit raises flags early. A wrong direction changes which flag the turn rules remove, so the bench checks the flag pattern at the last iteration against the rule bits. A wrong priority or a wrongly accepted flag reaches the write port only at the end of the run. The bench therefore checks `tbl_vld_o` and `tbl_dir_o` in the single done cycle. A miscounted run moves `done_o` by at least one cycle, and the bench checks the done pulse on the exact cycle.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int NDIR = 4;
  typedef enum logic [2:0] {
    DIR_N = 3'd0, DIR_E = 3'd1, DIR_S = 3'd2, DIR_W = 3'd3, DIR_LOCAL = 3'd4
  } dir_e;
  // highest priority first
  localparam dir_e PRIO [NDIR] = '{DIR_S, DIR_E, DIR_W, DIR_N};
endpackage

// File: rtl/rfe_prio_pick.sv
module rfe_prio_pick
  import rfe_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NDIR-1:0] flag_i,
  input  logic [NDIR-1:0] link_ok_i,
  output logic            any_o,
  output dir_e            dir_o
);
  logic [NDIR-1:0] acc;
  logic [NDIR-1:0] grant;

  assign acc   = flag_i & link_ok_i;
  assign any_o = |acc;

  always_comb begin
    grant = '0;
    dir_o = DIR_N;
    for (int i = NDIR - 1; i >= 0; i--) begin
      if (acc[PRIO[i][1:0]]) begin
        grant = '0;
        grant[PRIO[i][1:0]] = 1'b1;
        dir_o = PRIO[i];
      end
    end
  end

  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~acc) == '0));
  // R8
  blocked_not_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> link_ok_i[dir_o[1:0]]);
endmodule

// File: rtl/rfe_flag_gate.sv
module rfe_flag_gate
  import rfe_pkg::*;
#(
  parameter bit NE_RULE = 1'b1
) (
  input  logic                 active_i,
  input  logic                 vld_i,
  input  dir_e                 dir_i,
  input  logic [NDIR-1:0]      link_ok_i,
  input  logic [NDIR*NDIR-1:0] turn_block_i,
  output logic [NDIR-1:0]      flag_o
);
  localparam logic [NDIR*NDIR-1:0] NE_MASK =
    NE_RULE ? ((NDIR*NDIR)'(1) << (DIR_N*NDIR + DIR_E)) |
              ((NDIR*NDIR)'(1) << (DIR_E*NDIR + DIR_N)) : '0;

  logic [NDIR*NDIR-1:0] rules;
  assign rules = turn_block_i | NE_MASK;

  for (genvar k = 0; k < NDIR; k++) begin : g_link
    logic turn_hit;
    assign turn_hit  = (dir_i != DIR_LOCAL) && rules[k*NDIR + int'(dir_i[1:0])];
    assign flag_o[k] = active_i && vld_i && link_ok_i[k] && !turn_hit;
  end
endmodule

// File: rtl/rfe_seq.sv
module rfe_seq #(
  parameter int NODES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (NODES > 2) ? $clog2(NODES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NODES - 2);

  logic [CW-1:0] cnt_q;
  logic [31:0]   chk_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // independent run-length counter for the checker
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chk_len <= '0;
    else if (start_i) chk_len <= '0;
    else if (busy_o)  chk_len <= chk_len + 1;
  end

  // R6
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (chk_len == 32'(NODES - 1)));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/route_flood_engine.sv
module route_flood_engine
  import rfe_pkg::*;
#(
  parameter int NODES   = 16,
  parameter int ID_W    = 4,
  parameter bit NE_RULE = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [ID_W-1:0]      dest_id_i,
  input  logic [ID_W-1:0]      self_id_i,
  input  logic [3:0]           link_fault_i,
  input  logic [3:0]           link_block_i,
  input  logic [15:0]          turn_block_i,
  input  logic [3:0]           flag_i,
  output logic [3:0]           flag_o,
  output logic                 tbl_we_o,
  output logic [ID_W-1:0]      tbl_addr_o,
  output logic                 tbl_vld_o,
  output logic [2:0]           tbl_dir_o,
  output logic                 done_o
);
  logic            busy, done;
  logic            ent_vld;
  dir_e            ent_dir;
  logic [ID_W-1:0] dest_q;
  logic [NDIR-1:0] link_ok;
  logic            rx_any;
  dir_e            rx_dir;

  assign link_ok = ~(link_fault_i | link_block_i);

  rfe_seq #(.NODES(NODES)) u_seq (
    .clk_i, .rst_ni, .start_i, .busy_o(busy), .done_o(done)
  );

  rfe_prio_pick u_pick (
    .clk_i, .rst_ni, .flag_i, .link_ok_i(link_ok), .any_o(rx_any), .dir_o(rx_dir)
  );

  rfe_flag_gate #(.NE_RULE(NE_RULE)) u_gate (
    .active_i(busy), .vld_i(ent_vld), .dir_i(ent_dir),
    .link_ok_i(link_ok), .turn_block_i, .flag_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld <= 1'b0;
      ent_dir <= DIR_N;
      dest_q  <= '0;
    end else if (start_i) begin
      ent_vld <= (dest_id_i == self_id_i);
      ent_dir <= (dest_id_i == self_id_i) ? DIR_LOCAL : DIR_N;
      dest_q  <= dest_id_i;
    end else if (busy && !ent_vld && rx_any) begin
      ent_vld <= 1'b1;
      ent_dir <= rx_dir;
    end
  end

  assign tbl_we_o   = done;
  assign done_o     = done;
  assign tbl_addr_o = dest_q;
  assign tbl_vld_o  = ent_vld;
  assign tbl_dir_o  = ent_dir;

  // R1
  idle_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (flag_o == '0));
  // R3
  invalid_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ent_vld |-> (flag_o == '0));
  // R4
  entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_vld && !start_i) |=> (ent_vld && $stable(ent_dir)));
  // R8
  fault_no_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((link_fault_i | link_block_i) & flag_o) == '0);
  // R10
  ne_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (NE_RULE && ent_vld && ent_dir == DIR_E) |-> !flag_o[0]);
endmodule

// File: tb/route_flood_engine_tb.sv
module route_flood_engine_tb_top;
  localparam int NODES = 16;
  localparam int ID_W  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [ID_W-1:0] dest_id = '0, self_id = 4'd5;
  logic [3:0]      lfault = '0, lblock = '0, flag_in = '0;
  logic [15:0]     tblock = '0;
  logic [3:0]      flag_out;
  logic            we, vld, done;
  logic [ID_W-1:0] addr;
  logic [2:0]      dir;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  route_flood_engine #(.NODES(NODES), .ID_W(ID_W), .NE_RULE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dest_id_i(dest_id),
    .self_id_i(self_id), .link_fault_i(lfault), .link_block_i(lblock),
    .turn_block_i(tblock), .flag_i(flag_in), .flag_o(flag_out),
    .tbl_we_o(we), .tbl_addr_o(addr), .tbl_vld_o(vld), .tbl_dir_o(dir),
    .done_o(done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flags fa applied in iteration ia, fb in iteration ib (1..NODES-1).
  task automatic run(string req, logic [ID_W-1:0] dst, logic [3:0] flt,
                     logic [3:0] blk, logic [15:0] tb, int ia, logic [3:0] fa,
                     int ib, logic [3:0] fb, logic ev, logic [2:0] ed,
                     logic [3:0] eflags);
    @(negedge clk);
    dest_id = dst; lfault = flt; lblock = blk; tblock = tb; flag_in = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int m = 1; m <= NODES; m++) begin
      if (m == NODES) begin
        chk({req, " done"}, {31'd0, done}, 1);
        chk({req, " we"}, {31'd0, we}, 1);
        chk({req, " valid"}, {31'd0, vld}, {31'd0, ev});
        if (ev) chk({req, " dir"}, {29'd0, dir}, {29'd0, ed});
        chk({req, " addr"}, {28'd0, addr}, {28'd0, dst});
        chk({req, " idle flags"}, {28'd0, flag_out}, 0);
      end else begin
        if (m == NODES - 1) begin
          chk({req, " early done"}, {31'd0, done}, 0);
          chk({req, " flags"}, {28'd0, flag_out}, {28'd0, eflags});
        end
        flag_in = (m == ia ? fa : 4'h0) | (m == ib ? fb : 4'h0);
        @(negedge clk);
      end
    end
    flag_in = '0;
    @(negedge clk);
    chk({req, " done pulse"}, {31'd0, done}, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 flags", {28'd0, flag_out}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 we", {31'd0, we}, 0);
    rst_n = 1'b1;
    // R2 destination is local, floods all links
    run("R2", 4'd5, 4'h0, 4'h0, 16'h0, 0, 4'h0, 0, 4'h0, 1'b1, 3'd4, 4'hF);
    // R7 unreachable
    run("R7", 4'd2, 4'h0, 4'h0, 16'h0, 0, 4'h0, 0, 4'h0, 1'b0, 3'd0, 4'h0);
    // R4 single west flag, then R3 flood
    run("R4", 4'd2, 4'h0, 4'h0, 16'h0, 3, 4'h8, 0, 4'h0, 1'b1, 3'd3, 4'hF);
    // R4 later flags ignored
    run("R4 hold", 4'd2, 4'h0, 4'h0, 16'h0, 1, 4'h4, 5, 4'hB, 1'b1, 3'd2, 4'hF);
    // R5 priorities
    run("R5 s", 4'd2, 4'h0, 4'h0, 16'h0, 2, 4'hF, 0, 4'h0, 1'b1, 3'd2, 4'hF);
    run("R5 e", 4'd2, 4'h0, 4'h0, 16'h0, 2, 4'hB, 0, 4'h0, 1'b1, 3'd1, 4'hE);
    run("R5 w", 4'd2, 4'h0, 4'h0, 16'h0, 2, 4'h9, 0, 4'h0, 1'b1, 3'd3, 4'hF);
    // R10 north entry: no flag east
    run("R10", 4'd2, 4'h0, 4'h0, 16'h0, 4, 4'h1, 0, 4'h0, 1'b1, 3'd0, 4'hD);
    // R8 faulty south ignored in and out
    run("R8 fault", 4'd2, 4'h4, 4'h0, 16'h0, 2, 4'h6, 0, 4'h0, 1'b1, 3'd1, 4'hA);
    run("R8 block", 4'd2, 4'h0, 4'h2, 16'h0, 2, 4'h2, 0, 4'h0, 1'b0, 3'd0, 4'h0);
    // R9 custom turn: entry west (3), no flag south -> bit 2*4+3=11
    run("R9", 4'd2, 4'h0, 4'h0, 16'h0800, 6, 4'h8, 0, 4'h0, 1'b1, 3'd3, 4'hB);
    // R9 local entry ignores turn rules
    run("R9 local", 4'd5, 4'h0, 4'h0, 16'hFFFF, 0, 4'h0, 0, 4'h0, 1'b1, 3'd4, 4'hF);
    // R6 flag in final iteration still counts
    run("R6", 4'd2, 4'h0, 4'h0, 16'h0, NODES - 1, 4'h4, 0, 4'h0, 1'b1, 3'd2, 4'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule